// File: doc/BRIEF.md
# Card Presence Detector with Glitch Filter

This block watches the mechanical presence switch of a single card slot and turns its noisy raw level into a clean "card present" status. The raw pin is first brought into the clock domain by a two-stage synchroniser. A new level must then hold without interruption for a minimum span before the block accepts it. That span is set in clock cycles and derived from the clock frequency, so that it covers at least 50 microseconds. Anything shorter is treated as contact bounce or noise and is discarded.

A run-time polarity bit tells the block how the switch is wired, either normally open or normally closed, and so decides which raw level means that a card is inserted. After reset the setting is normally open. Each accepted change of the filtered level sets an interrupt request, which stays high until software acknowledges it. Flipping the polarity bit only changes how the stored level is reported. It sets no interrupt.

Top module: `card_presence_filter`

## Requirements
- R1: After reset, with the raw pin low and the polarity bit low, `card_present` is 0 and `irq` is 0.
- R2: With `pol_nc` = 0 (normally open), `card_present` is 1 when the filtered raw level is high. With `pol_nc` = 1 (normally closed), it is 1 when the filtered raw level is low.
- R3: If the raw level differs from the filtered level for fewer than FILT_CYCLES consecutive sampling edges, `card_present` does not change and `irq` is not set.
- R4: If a new raw level holds for at least FILT_CYCLES edges, `card_present` changes on the (FILT_CYCLES+2)-th rising edge after the raw change, and not earlier. Two of those edges are used by the synchroniser.
- R5: `irq` goes high on the same edge as an accepted change of the filtered level.
- R6: `irq` stays high until `irq_ack` is sampled high. It is then low after that edge, provided no new change is accepted on the same edge.
- R7: If an accepted change and `irq_ack` fall on the same edge, `irq` is high after that edge.
- R8: A change of `pol_nc` inverts `card_present` at once, without a clock edge, and does not set `irq`.
- R9: FILT_CYCLES defaults to ceil(CLK_HZ × HOLD_US / 1,000,000), the smallest whole number of clock cycles that spans HOLD_US microseconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| det_raw | input | 1 | Raw level from the presence switch, asynchronous |
| pol_nc | input | 1 | Switch polarity: 0 for normally open, 1 for normally closed |
| irq_ack | input | 1 | Interrupt acknowledge, one-cycle pulse |
| card_present | output | 1 | Filtered card presence status |
| irq | output | 1 | Interrupt request, set on each accepted presence change |

## Verification
The bench builds the block with CLK_HZ = 100,000 and HOLD_US = 50, which gives a filter length of five cycles. With so short a filter, every pulse width from one cycle to just past the threshold can be swept in both directions and under both polarities. The acceptance edge can be pinned to the exact cycle. An acknowledge can also be placed on the very edge where a change is accepted.

// File: rtl/card_presence_filter.sv
module card_presence_filter #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int HOLD_US     = 50,
  parameter int FILT_CYCLES = int'((longint'(CLK_HZ) * longint'(HOLD_US) + 64'd999_999) / 64'd1_000_000)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_raw,
  input  logic pol_nc,
  input  logic irq_ack,
  output logic card_present,
  output logic irq
);
  localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);

  logic          sync_a, sync_b;
  logic          filt_q;
  logic [CW-1:0] run_q;
  logic          differs, accept;

  assign differs = sync_b != filt_q;
  assign accept  = differs && (run_q == CW'(FILT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= det_raw;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (accept) begin
      run_q  <= '0;
      filt_q <= sync_b;
    end else if (differs) begin
      run_q  <= run_q + 1'b1;
    end else begin
      run_q  <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= accept | (irq & ~irq_ack);
  end

  assign card_present = filt_q ^ pol_nc;
endmodule

// File: rtl/card_presence_filter_chk.sv
module card_presence_filter_chk #(
  parameter int N = 5
) (
  input logic clk,
  input logic rst_n,
  input logic det_raw,
  input logic pol_nc,
  input logic irq_ack,
  input logic card_present,
  input logic irq,
  input logic filt
);
  localparam int RW = $clog2(N + 1);

  logic          d1, d2;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1  <= 1'b0;
      d2  <= 1'b0;
      run <= '0;
    end else begin
      d1 <= det_raw;
      d2 <= d1;
      if (d1 != d2)          run <= RW'(1);
      else if (run < RW'(N)) run <= run + 1'b1;
    end
  end

  a_r3_glitch_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> ($past(run) >= RW'(N)) && (filt == $past(d2)));

  a_r5_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> irq);

  a_r5_irq_only_from_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$stable(filt));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_ack) && $stable(filt) |-> !irq);

  a_r8_pol_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol_nc) && $stable(filt) |-> card_present != $past(card_present));
endmodule

bind card_presence_filter card_presence_filter_chk #(.N(FILT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .det_raw(det_raw), .pol_nc(pol_nc),
  .irq_ack(irq_ack), .card_present(card_present), .irq(irq), .filt(filt_q)
);

// File: tb/tb_card_presence_filter.sv
module tb_card_presence_filter;
  localparam int CLK_HZ  = 100_000;
  localparam int HOLD_US = 50;
  localparam int N = (CLK_HZ * HOLD_US + 999_999) / 1_000_000;

  logic clk = 1'b0;
  logic rst_n, det_raw, pol_nc, irq_ack;
  logic card_present, irq;
  int   errors = 0, checks = 0;
  logic fr = 1'b0;

  always #10 clk = ~clk;

  card_presence_filter #(.CLK_HZ(CLK_HZ), .HOLD_US(HOLD_US)) dut (
    .clk(clk), .rst_n(rst_n), .det_raw(det_raw), .pol_nc(pol_nc),
    .irq_ack(irq_ack), .card_present(card_present), .irq(irq)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    cycles(1);
    irq_ack = 1'b0;
  endtask

  task automatic step_level(logic lvl, string req);
    det_raw = lvl;
    cycles(N + 1);
    check({req, " not yet changed at edge N+1"}, card_present, fr ^ pol_nc);
    cycles(1);
    fr = lvl;
    check({req, " changed at edge N+2"}, card_present, fr ^ pol_nc);
    check("R5 irq with change", irq, 1'b1);
  endtask

  task automatic pulse(int w);
    logic base;
    logic accepted;
    base = fr;
    accepted = (w >= N);
    ack_pulse();
    cycles(1);
    det_raw = ~base;
    for (int k = 1; k <= N + 2; k++) begin
      @(negedge clk);
      if (k == w) det_raw = base;
    end
    check(accepted ? "R4 long pulse accepted" : "R3 short pulse ignored",
          card_present, (accepted ? ~base : base) ^ pol_nc);
    cycles(w + 2 * N + 4);
    if (det_raw !== base) det_raw = base;
    cycles(N + 4);
    check("R3 level restored", card_present, base ^ pol_nc);
    check(accepted ? "R5 irq after accepted pulse" : "R3 no irq after glitch",
          irq, accepted);
  endtask

  initial begin
    #(200_000 * 20);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; det_raw = 1'b0; pol_nc = 1'b0; irq_ack = 1'b0;
    cycles(4);
    rst_n = 1'b1;
    cycles(1);
    check("R1 reset present", card_present, 1'b0);
    check("R1 reset irq", irq, 1'b0);
    check("R9 filter length", (N == 5), 1'b1);

    for (int w = 1; w <= N + 2; w++) pulse(w);

    ack_pulse();
    step_level(1'b1, "R4 rise pol0");
    check("R2 normally open high means present", card_present, 1'b1);
    cycles(6);
    check("R6 irq held", irq, 1'b1);
    ack_pulse();
    check("R6 irq cleared", irq, 1'b0);

    pol_nc = 1'b1;
    #1;
    check("R8 polarity inverts at once", card_present, 1'b0);
    cycles(6);
    check("R8 no irq from polarity", irq, 1'b0);
    check("R2 normally closed high means absent", card_present, 1'b0);

    for (int w = 1; w <= N + 2; w++) pulse(w);

    ack_pulse();
    step_level(1'b0, "R4 fall pol1");
    check("R2 normally closed low means present", card_present, 1'b1);

    det_raw = 1'b1;
    cycles(N + 1);
    irq_ack = 1'b1;
    cycles(1);
    irq_ack = 1'b0;
    fr = 1'b1;
    check("R7 change with ack keeps irq", irq, 1'b1);
    check("R4 change with ack", card_present, 1'b0);
    cycles(2);
    check("R6 still held", irq, 1'b1);
    ack_pulse();
    check("R6 cleared after ack", irq, 1'b0);

    pol_nc = 1'b0;
    #1;
    check("R8 polarity back", card_present, 1'b1);
    cycles(4);
    check("R8 no irq on return", irq, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule